// File: doc/BRIEF.md
# Cut-off Beam Current Sample Trigger

This block takes one snapshot of the three cathode beam currents (red, green, blue) at a chosen place in the video frame. Software writes a line-block number and then a control byte with the start bit set and the select bit clear. The block then waits for the next rising edge of vertical sync. It counts four horizontal-sync rising edges for each line block and waits for the next rising edge of the flyback input. After a programmable even number of clock periods it latches all three converter outputs at once. The start bit reads 1 for the whole capture and drops to 0 by itself when the result is ready.

The converters are outside the block; their 8-bit outputs arrive as parallel inputs that the block samples on its own clock. The sync and flyback inputs are asynchronous. Each passes through a two-flop synchroniser and then a rising-edge detector. A soft-reset input abandons a capture in progress. The register interface is a simple single-cycle write port with a combinational read mux; its address decode and field positions are fixed below.

Top module: `cutoff_sample_seq`

## Requirements
- R1: After reset every register reads 0x00: red result, green result, blue result, line block and control.
- R2: The addresses are 0 red result, 1 green result, 2 blue result, 3 line block and 4 control; any other address reads 0x00. Control holds bit 7 start, bits 6:5 frame count, bits 4:2 delay code D and bit 0 select. Bit 1 always reads 0, and the frame count has no effect in this mode.
- R3: A control write with bit 7 = 1 and bit 0 = 0 while idle starts a capture. Bit 7 then reads 1 until the three results are latched, and reads 0 from the next cycle on. A later start works the same way.
- R4: A control write with bit 0 = 1 stores the fields but starts nothing: bit 7 reads 0 and the results do not change, whatever sync activity follows.
- R5: After start, horizontal sync and flyback edges are ignored until a rising edge of vertical sync is seen.
- R6: After vertical sync, exactly 4×N rising edges of horizontal sync must be counted (N = line block) before a flyback rising edge is accepted. Earlier flyback edges are ignored. With N = 0 the first flyback edge after vertical sync is used.
- R7: The latched value is the converter input present at rising clock edge 4 + 2×D, counting from the first edge after the flyback input rises. This gives a delay that can be set from 0 to 14 clocks in steps of two.
- R8: All three results are latched on the same edge and keep their value until the next completed capture.
- R9: While a capture is in progress, writes to the control and line-block registers are ignored.
- R10: Soft reset aborts a capture: bit 7 reads 0, later sync edges latch nothing, and the line block and control fields are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all sampling and delays count this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous abort of the sequence |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| flyback_in | input | 1 | Horizontal flyback, asynchronous |
| adc_red | input | 8 | Red beam-current converter output |
| adc_grn | input | 8 | Green beam-current converter output |
| adc_blu | input | 8 | Blue beam-current converter output |

## Verification
The hardest case to reach is the exact clock on which the converters are sampled. It depends on synchroniser latency, edge detection and the delay countdown, and the result registers alone cannot show it. The bench drives all three converter inputs from a counter that advances every clock, each channel with a different mapping. The latched value therefore shows exactly which edge was used. Random line-block and delay codes are mixed with directed runs that send flyback too early, before vertical sync, after an abort and with a line block of zero.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_VS,
    ST_COUNT_HS,
    ST_WAIT_FLY,
    ST_DELAY
  } seq_state_t;

  localparam int ADDR_RED = 0;
  localparam int ADDR_GRN = 1;
  localparam int ADDR_BLU = 2;
  localparam int ADDR_BLK = 3;
  localparam int ADDR_CTL = 4;

  localparam int CTL_START_BIT = 7;
  localparam int CTL_SEL_BIT   = 0;
endpackage

// File: rtl/cs_sync_edge.sv
module cs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  genvar i;
  generate
    for (i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its history
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cs_regs.sv
module cs_regs
  import cs_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic              latch,
  input  logic [REG_W-1:0]  adc_r,
  input  logic [REG_W-1:0]  adc_g,
  input  logic [REG_W-1:0]  adc_b,
  output logic              start_req,
  output logic [REG_W-1:0]  blk,
  output logic [DLY_W-1:0]  dly,
  output logic [REG_W-1:0]  res_r,
  output logic [REG_W-1:0]  res_g,
  output logic [REG_W-1:0]  res_b
);
  logic [1:0] frames;
  logic       sel;
  logic       wr_ctl, wr_blk;

  assign wr_ctl = wr && (addr == ADDR_W'(ADDR_CTL)) && !busy;
  assign wr_blk = wr && (addr == ADDR_W'(ADDR_BLK)) && !busy;
  assign start_req = wr_ctl && wdata[CTL_START_BIT] && !wdata[CTL_SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk    <= '0;
      frames <= '0;
      dly    <= '0;
      sel    <= 1'b0;
    end else begin
      if (wr_blk) blk <= wdata;
      if (wr_ctl) begin
        frames <= wdata[6:5];
        dly    <= wdata[2 +: DLY_W];
        sel    <= wdata[CTL_SEL_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_r <= '0;
      res_g <= '0;
      res_b <= '0;
    end else if (latch) begin
      res_r <= adc_r;
      res_g <= adc_g;
      res_b <= adc_b;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(ADDR_RED): rdata = res_r;
      ADDR_W'(ADDR_GRN): rdata = res_g;
      ADDR_W'(ADDR_BLU): rdata = res_b;
      ADDR_W'(ADDR_BLK): rdata = blk;
      ADDR_W'(ADDR_CTL): rdata = {busy, frames, dly, 1'b0, sel};
      default:           rdata = '0;
    endcase
  end
endmodule

// File: rtl/cs_seq.sv
module cs_seq
  import cs_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start_req,
  input  logic             vs_rise,
  input  logic             hs_rise,
  input  logic             fly_rise,
  input  logic [BLK_W-1:0] blk,
  input  logic [DLY_W-1:0] dly,
  output logic             busy,
  output logic             latch
);
  localparam int LCNT_W = BLK_W + 2;
  localparam int DCNT_W = DLY_W + 1;

  seq_state_t        state;
  logic [LCNT_W-1:0] line_cnt;
  logic [LCNT_W-1:0] target;
  logic [DCNT_W-1:0] dcnt;

  assign target = {blk, 2'b00};
  assign busy   = (state != ST_IDLE);
  assign latch  = (state == ST_DELAY) && (dcnt == '0) && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      line_cnt <= '0;
      dcnt     <= '0;
    end else if (soft_rst) begin
      state    <= ST_IDLE;
      line_cnt <= '0;
      dcnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) state <= ST_WAIT_VS;
        end
        ST_WAIT_VS: begin
          if (vs_rise) begin
            line_cnt <= '0;
            state    <= (target == '0) ? ST_WAIT_FLY : ST_COUNT_HS;
          end
        end
        ST_COUNT_HS: begin
          if (hs_rise) begin
            if (line_cnt + 1'b1 == target) state <= ST_WAIT_FLY;
            line_cnt <= line_cnt + 1'b1;
          end
        end
        ST_WAIT_FLY: begin
          if (fly_rise) begin
            dcnt  <= {dly, 1'b0};
            state <= ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (dcnt == '0) state <= ST_IDLE;
          else            dcnt  <= dcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cutoff_sample_seq.sv
module cutoff_sample_seq #(
  parameter int REG_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int DLY_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic              flyback_in,
  input  logic [REG_W-1:0]  adc_red,
  input  logic [REG_W-1:0]  adc_grn,
  input  logic [REG_W-1:0]  adc_blu
);
  logic             vs_rise, hs_rise, fly_rise;
  logic             busy, latch, start_req;
  logic [REG_W-1:0] blk;
  logic [DLY_W-1:0] dly;
  logic [REG_W-1:0] res_r, res_g, res_b;

  cs_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst_n(rst_n), .din(vsync_in), .rise(vs_rise));
  cs_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_n), .din(hsync_in), .rise(hs_rise));
  cs_sync_edge #(.STAGES(SYNC_STAGES)) u_fly (
    .clk(clk), .rst_n(rst_n), .din(flyback_in), .rise(fly_rise));

  cs_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .busy(busy), .latch(latch),
    .adc_r(adc_red), .adc_g(adc_grn), .adc_b(adc_blu),
    .start_req(start_req), .blk(blk), .dly(dly),
    .res_r(res_r), .res_g(res_g), .res_b(res_b));

  cs_seq #(.BLK_W(REG_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .start_req(start_req),
    .vs_rise(vs_rise), .hs_rise(hs_rise), .fly_rise(fly_rise),
    .blk(blk), .dly(dly),
    .busy(busy), .latch(latch));
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              busy,
  input logic              latch,
  input logic [REG_W-1:0]  blk,
  input logic [REG_W-1:0]  res_r,
  input logic [REG_W-1:0]  res_g,
  input logic [REG_W-1:0]  res_b
);
  logic ctl_wr, blk_wr;
  assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(4));
  assign blk_wr = reg_wr && (reg_addr == ADDR_W'(3));

  assert_bit1_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(4)) |-> !reg_rdata[1]);

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_wr && reg_wdata[7] && !reg_wdata[0] && !soft_rst) |=> busy);

  assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !busy);

  assert_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_wr && reg_wdata[0]) |=> !busy);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable({res_r, res_g, res_b}));

  assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blk_wr) |=> $stable(blk));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy);
endmodule

bind cutoff_sample_seq cs_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .busy(busy), .latch(latch), .blk(blk),
  .res_r(res_r), .res_g(res_g), .res_b(res_b));

// File: tb/cutoff_sample_seq_tb.sv
module cutoff_sample_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       vs = 1'b0, hs = 1'b0, fly = 1'b0;
  logic [7:0] cnt = 8'd0;
  logic [7:0] adc_r, adc_g, adc_b;

  int tests = 0;
  int fails = 0;
  logic [7:0] last_r = 8'd0, last_g = 8'd0, last_b = 8'd0;

  always #10 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 8'd1;
  assign adc_r = cnt;
  assign adc_g = ~cnt;
  assign adc_b = cnt ^ 8'hA5;

  cutoff_sample_seq u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vsync_in(vs), .hsync_in(hs), .flyback_in(fly),
    .adc_red(adc_r), .adc_grn(adc_g), .adc_blu(adc_b));

  function automatic logic [7:0] exp_sample(int c, int d);
    return 8'(c + 4 - 1 + 2 * d);
  endfunction

  function automatic logic [7:0] ctl_byte(bit st, int fr, int d, bit sel);
    return {st, 2'(fr), 3'(d), 1'b0, sel};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #2;
    v = reg_rdata;
  endtask

  task automatic pulse(input int which, input int times);
    for (int k = 0; k < times; k++) begin
      @(negedge clk);
      if (which == 0) vs = 1'b1; else hs = 1'b1;
      repeat (3) @(negedge clk);
      vs = 1'b0; hs = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic flyback(output int c);
    @(negedge clk);
    #1;
    fly = 1'b1;
    c = cnt;
    repeat (3) @(negedge clk);
    fly = 1'b0;
    repeat (25) @(negedge clk);
  endtask

  task automatic check_results(string req, logic [7:0] er, logic [7:0] eg,
                               logic [7:0] eb);
    logic [7:0] v;
    rd(3'd0, v); check(req, v, er);
    rd(3'd1, v); check(req, v, eg);
    rd(3'd2, v); check(req, v, eb);
  endtask

  task automatic expect_capture(string req, int c, int d);
    logic [7:0] e;
    e = exp_sample(c, d);
    last_r = e; last_g = ~e; last_b = e ^ 8'hA5;
    check_results(req, last_r, last_g, last_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c, n, d, fr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values; R2: unused address reads zero
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 reset", v, 8'h00);
    end
    rd(3'd7, v); check("R2 unused addr", v, 8'h00);

    // R2: bit 1 reads 0, fields read back
    wr(3'd4, 8'h7E);
    rd(3'd4, v); check("R2 layout", v, 8'h7C);

    // R4: select=1 never starts
    wr(3'd3, 8'd1);
    wr(3'd4, 8'hE1);
    rd(3'd4, v); check("R4 select start", v, 8'h61);
    pulse(0, 1); pulse(1, 4); flyback(c);
    check_results("R4 no capture", 8'h00, 8'h00, 8'h00);

    // R3/R7/R8: random captures
    for (int it = 0; it < 10; it++) begin
      n  = $urandom_range(1, 3);
      d  = $urandom_range(0, 7);
      fr = $urandom_range(0, 3);
      wr(3'd3, 8'(n));
      wr(3'd4, ctl_byte(1'b1, fr, d, 1'b0));
      rd(3'd4, v); check("R3 start reads 1", v, ctl_byte(1'b1, fr, d, 1'b0));
      pulse(0, 1); pulse(1, 4 * n); flyback(c);
      expect_capture("R7 R8 random capture", c, d);
      rd(3'd4, v); check("R3 start cleared", v, ctl_byte(1'b0, fr, d, 1'b0));
    end

    // R7: delay corners 0 and 7
    wr(3'd3, 8'd1);
    wr(3'd4, ctl_byte(1'b1, 0, 0, 1'b0));
    pulse(0, 1); pulse(1, 4); flyback(c);
    expect_capture("R7 delay 0", c, 0);
    wr(3'd4, ctl_byte(1'b1, 0, 7, 1'b0));
    pulse(0, 1); pulse(1, 4); flyback(c);
    expect_capture("R7 delay 14", c, 7);

    // R5: edges before vertical sync ignored
    wr(3'd4, 8'h80);
    pulse(1, 4); flyback(c);
    rd(3'd4, v); check("R5 still waiting", v, 8'h80);
    check_results("R5 no early capture", last_r, last_g, last_b);
    pulse(0, 1); pulse(1, 4); flyback(c);
    expect_capture("R5 capture after vsync", c, 0);

    // R6 + R9: early flyback ignored, writes while busy ignored
    wr(3'd3, 8'd2);
    wr(3'd4, 8'h84);
    wr(3'd3, 8'd3);
    wr(3'd4, 8'h00);
    rd(3'd3, v); check("R9 line block locked", v, 8'd2);
    rd(3'd4, v); check("R9 control locked", v, 8'h84);
    pulse(0, 1); pulse(1, 7); flyback(c);
    rd(3'd4, v); check("R6 early flyback ignored", v, 8'h84);
    check_results("R6 no capture", last_r, last_g, last_b);
    pulse(1, 1); flyback(c);
    expect_capture("R6 capture after 4N", c, 1);

    // R6: line block zero
    wr(3'd3, 8'd0);
    wr(3'd4, 8'h88);
    pulse(0, 1); flyback(c);
    expect_capture("R6 block zero", c, 2);

    // R10: soft reset aborts
    wr(3'd3, 8'd1);
    wr(3'd4, 8'h8C);
    pulse(0, 1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(3'd4, v); check("R10 start cleared", v, 8'h0C);
    rd(3'd3, v); check("R10 block kept", v, 8'd1);
    pulse(1, 4); flyback(c);
    check_results("R10 no capture", last_r, last_g, last_b);

    // R3: restart after abort
    wr(3'd4, 8'h8C);
    pulse(0, 1); pulse(1, 4); flyback(c);
    expect_capture("R3 restart", c, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule